// File: doc/BRIEF.md
# Dual-Bank Asynchronous SRAM Controller

This block sits between an internal ready/valid request port and an external asynchronous static memory. The memory is built from two byte-wide banks of 512K locations each. The banks share the address lines, a single write strobe and one bidirectional byte bus. Each bank has its own active-low select. The top bit of a 20-bit request address chooses the bank. The remaining 19 bits go out on the shared address lines.

The memory's output enable is permanently active, so a selected bank drives the bus whenever the write strobe is high. The controller prevents contention by ordering the select, the write strobe and its own bus drivers. After the write strobe falls, it waits a set number of cycles before driving data. It releases the bus on the same edge that the strobe rises. It also adds idle cycles when a read is followed by a write. All memory timing minimums are integer cycle counts set by parameters, each rounded up from the nanosecond figure and the clock period.

A read keeps the select low for a fixed access count. The bus is sampled into a register on the last cycle of that count, and the byte is returned with a one-cycle valid pulse. The request port accepts one word at a time and holds ready low until the current memory cycle has finished.

Top module: `sram_bank_ctrl`

## Requirements
- R1: Request address bit 19 selects the bank. When it is 0, select bit 0 (`sram_sel_n_o[0]`, the lower bank) goes low. When it is 1, select bit 1 (the upper bank) goes low. Request bits 18:0 appear on `sram_addr_o` for the whole access.
- R2: The two select bits are never low at the same time.
- R3: A read accepted on edge E holds the chosen select low, the write strobe high and the drivers off for RD_CYC cycles. The bus is sampled on edge E+RD_CYC. `rsp_valid_o` is high for exactly the one cycle after that edge, with the sampled byte on `rsp_rdata_o`.
- R4: A write holds the write strobe low for WHZ_CYC + max(DW_CYC, WP_CYC - WHZ_CYC) cycles. The drivers stay off for the first WHZ_CYC of those cycles and are on for the rest. The drivers turn off on the same edge that the write strobe rises, and the memory stores the request byte.
- R5: `req_ready_o` is low from the accepting edge until the memory cycle has ended. It is high whenever the controller is idle.
- R6: A write that follows a read first spends TURN_CYC cycles with both selects and the write strobe high. Only then does the write strobe fall.
- R7: Both selects are high for at least one cycle between any two accesses, including a change from one bank to the other.
- R8: The drivers are never on while any select is low and the write strobe is high.
- R9: After reset, both selects and the write strobe are high, the drivers are off, `rsp_valid_o` is low and `req_ready_o` is high.
- R10: The byte on `sram_dq_o` does not change while the drivers are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Byte address; bit 19 picks the bank |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle pulse with read data |
| rsp_rdata_o | output | 8 | Read data |
| sram_addr_o | output | 19 | Shared memory address |
| sram_sel_n_o | output | 2 | Active-low bank selects: bit 0 lower bank, bit 1 upper bank |
| sram_we_no | output | 1 | Active-low write strobe |
| sram_dq_o | output | 8 | Byte driven onto the bus |
| sram_dq_oe_o | output | 1 | Bus driver enable |
| sram_dq_i | input | 8 | Byte read from the bus |

## Verification
Every result is due a fixed number of edges after the accepting edge E. The first register update shows the access state after E. Read data appears with `rsp_valid_o` after E+RD_CYC. The write strobe falls after E, or after E+TURN_CYC when the write follows a read. The drivers come on WHZ_CYC edges later, and the strobe, drivers and selects all return after the drive window closes. The bench drives inputs and samples outputs on the falling clock edge. It walks through these cycles one at a time, comparing each cycle against the count it expects, so an early or late change shows up as a mismatch in a named cycle. Free-running monitors check select exclusivity, the gap between banks and bus contention on every cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_RD,
    ST_WR_HZ,
    ST_WR_DRV
  } seq_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_bank_decode.sv
module sram_bank_decode #(
  parameter int unsigned BANK_W    = 1,
  parameter int unsigned NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_act_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] sel_n_o
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
    assign sel_n_o[b] = !(sel_act_i && (bank_i == BANK_W'(b)));

    // no bank may follow another bank's select without an idle cycle
    assert_no_direct_switch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sel_n_o[b] && ($past(~sel_n_o) != '0)) |-> $past(!sel_n_o[b]));
  end

  assert_sel_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~sel_n_o));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= capture_i;
      if (capture_i) rsp_rdata_o <= dq_i;
    end
  end

  assert_rsp_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned BANK_W   = 1,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RD_CYC   = 1,
  parameter int unsigned WHZ_CYC  = 1,
  parameter int unsigned DRV_CYC  = 1,
  parameter int unsigned TURN_CYC = 1,
  localparam int unsigned MEM_AW  = ADDR_W - BANK_W,
  localparam int unsigned MAX_CYC = max_u(max_u(RD_CYC, WHZ_CYC), max_u(DRV_CYC, TURN_CYC)),
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              sel_act_o,
  output logic              we_n_o,
  output logic              drv_en_o,
  output logic [DATA_W-1:0] drv_data_o,
  output logic              capture_o
);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             after_rd_q;
  logic             cnt_done;

  assign cnt_done    = (cnt_q == '0);
  assign req_ready_o = (state_q == ST_IDLE);
  assign capture_o   = (state_q == ST_RD) && cnt_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      after_rd_q <= 1'b0;
      mem_addr_o <= '0;
      bank_o     <= '0;
      sel_act_o  <= 1'b0;
      we_n_o     <= 1'b1;
      drv_en_o   <= 1'b0;
      drv_data_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            mem_addr_o <= req_addr_i[MEM_AW-1:0];
            bank_o     <= req_addr_i[ADDR_W-1:MEM_AW];
            drv_data_o <= req_wdata_i;
            if (!req_we_i) begin
              state_q   <= ST_RD;
              cnt_q     <= CNT_W'(RD_CYC - 1);
              sel_act_o <= 1'b1;
            end else if (after_rd_q) begin
              state_q <= ST_TURN;
              cnt_q   <= CNT_W'(TURN_CYC - 1);
            end else begin
              state_q   <= ST_WR_HZ;
              cnt_q     <= CNT_W'(WHZ_CYC - 1);
              sel_act_o <= 1'b1;
              we_n_o    <= 1'b0;
            end
          end
        end
        ST_TURN: begin
          if (cnt_done) begin
            state_q    <= ST_WR_HZ;
            cnt_q      <= CNT_W'(WHZ_CYC - 1);
            sel_act_o  <= 1'b1;
            we_n_o     <= 1'b0;
            after_rd_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RD: begin
          if (cnt_done) begin
            state_q    <= ST_IDLE;
            sel_act_o  <= 1'b0;
            after_rd_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WR_HZ: begin
          after_rd_q <= 1'b0;
          if (cnt_done) begin
            state_q  <= ST_WR_DRV;
            cnt_q    <= CNT_W'(DRV_CYC - 1);
            drv_en_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WR_DRV: begin
          if (cnt_done) begin
            state_q   <= ST_IDLE;
            sel_act_o <= 1'b0;
            we_n_o    <= 1'b1;
            drv_en_o  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_drv_needs_we_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> !we_n_o);

  assert_drv_after_hz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(!we_n_o));

  assert_release_with_we_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_o) |-> $fell(drv_en_o));

  assert_busy_not_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_act_o |-> !req_ready_o);

  assert_wdata_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o && $past(drv_en_o)) |-> $stable(drv_data_o));

  initial begin
    assert_cyc_min: assert (RD_CYC >= 1 && WHZ_CYC >= 1 && DRV_CYC >= 1 && TURN_CYC >= 1);
  end

endmodule

// File: rtl/sram_bank_ctrl.sv
module sram_bank_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned BANK_W   = 1,
  parameter int unsigned RD_CYC   = 1,
  parameter int unsigned WP_CYC   = 1,
  parameter int unsigned DW_CYC   = 1,
  parameter int unsigned WHZ_CYC  = 1,
  parameter int unsigned TURN_CYC = 1,
  localparam int unsigned NUM_BANKS = 1 << BANK_W,
  localparam int unsigned MEM_AW    = ADDR_W - BANK_W,
  localparam int unsigned DRV_CYC   = max_u(DW_CYC, (WP_CYC > WHZ_CYC) ? WP_CYC - WHZ_CYC : 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_we_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output logic                 rsp_valid_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic [MEM_AW-1:0]    sram_addr_o,
  output logic [NUM_BANKS-1:0] sram_sel_n_o,
  output logic                 sram_we_no,
  output logic [DATA_W-1:0]    sram_dq_o,
  output logic                 sram_dq_oe_o,
  input  logic [DATA_W-1:0]    sram_dq_i
);

  logic [BANK_W-1:0] bank;
  logic              sel_act;
  logic              capture;

  sram_cycle_seq #(
    .ADDR_W  (ADDR_W),
    .BANK_W  (BANK_W),
    .DATA_W  (DATA_W),
    .RD_CYC  (RD_CYC),
    .WHZ_CYC (WHZ_CYC),
    .DRV_CYC (DRV_CYC),
    .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o),
    .mem_addr_o (sram_addr_o),
    .bank_o     (bank),
    .sel_act_o  (sel_act),
    .we_n_o     (sram_we_no),
    .drv_en_o   (sram_dq_oe_o),
    .drv_data_o (sram_dq_o),
    .capture_o  (capture)
  );

  sram_bank_decode #(
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_act_i(sel_act),
    .bank_i   (bank),
    .sel_n_o  (sram_sel_n_o)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (capture),
    .dq_i       (sram_dq_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o)
  );

  // a memory driving the bus must never meet our drivers
  assert_no_contention_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~sram_sel_n_o != '0) && sram_we_no) |-> !sram_dq_oe_o);

endmodule

// File: tb/tb_sram_bank_ctrl.sv
`timescale 1ns/1ps
module tb_sram_bank_ctrl;

  localparam int RD_CYC = 2, WP_CYC = 3, DW_CYC = 1, WHZ_CYC = 1, TURN_CYC = 2;
  localparam int DRV_CYC = 2; // max(DW, WP-WHZ)

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, we_n, oe;
  logic [7:0]  rsp_rdata, dq_o, dq_i;
  logic [18:0] sram_addr;
  logic [1:0]  sel_n;

  int checks = 0, errors = 0, mon_fail = 0, wd_fail = 0;
  bit last_read = 1'b0;

  always #10 clk = ~clk;

  sram_bank_ctrl #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .DW_CYC(DW_CYC),
                   .WHZ_CYC(WHZ_CYC), .TURN_CYC(TURN_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sram_addr_o(sram_addr),
    .sram_sel_n_o(sel_n), .sram_we_no(we_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(oe), .sram_dq_i(dq_i));

  function automatic logic [7:0] init_val(input int b, input int a);
    return 8'(((b << 7) | (a & 'h7f)) ^ 'h5a);
  endfunction

  // memory model
  logic [7:0] mem_m   [0:1][0:255];
  logic       mem_set [0:1][0:255];
  int         act_b;
  assign act_b = sel_n[1] ? 0 : 1;
  assign dq_i  = ((sel_n != 2'b11) && we_n)
               ? (mem_set[act_b][sram_addr[7:0]] ? mem_m[act_b][sram_addr[7:0]]
                                                  : init_val(act_b, int'(sram_addr[7:0])))
               : 8'h00;

  logic [1:0] prev_sel = 2'b11;
  always @(negedge clk) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int a = 0; a < 256; a++) mem_set[b][a] <= 1'b0;
      prev_sel <= 2'b11;
    end else begin
      if (sel_n == 2'b00) begin
        mon_fail++; $display("FAIL R2 selects both low actual=%b expected=one high", sel_n);
      end
      if ((sel_n == 2'b10 && prev_sel == 2'b01) || (sel_n == 2'b01 && prev_sel == 2'b10)) begin
        mon_fail++; $display("FAIL R7 direct bank switch actual=%b expected=11 between", sel_n);
      end
      if (oe && sel_n != 2'b11 && we_n) begin
        mon_fail++; $display("FAIL R8 contention actual=oe1 we1 expected=oe0");
      end
      if (oe && sel_n != 2'b11 && !we_n) begin
        mem_m[act_b][sram_addr[7:0]]   <= dq_o;
        mem_set[act_b][sram_addr[7:0]] <= 1'b1;
      end
      prev_sel <= sel_n;
    end
  end

  logic [7:0] shadow [0:1][0:255];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors + mon_fail + wd_fail);
  endtask

  function automatic logic [1:0] sel_exp(input logic [19:0] a);
    return a[19] ? 2'b01 : 2'b10;
  endfunction

  task automatic launch(input bit we, input logic [19:0] a, input logic [7:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);          // accepting edge passed
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a);
    logic [7:0] exp = shadow[a[19]][a[7:0]];
    launch(1'b0, a, 8'h00);
    for (int i = 0; i < RD_CYC; i++) begin
      chk(sel_n == sel_exp(a) && we_n && !oe, "R1 read select", {sel_n, we_n, oe}, {sel_exp(a), 2'b10});
      chk(sram_addr == a[18:0], "R1 address", sram_addr, a[18:0]);
      chk(!req_ready, "R5 busy", req_ready, 0);
      chk(!rsp_valid, "R3 early valid", rsp_valid, 0);
      if (i != RD_CYC - 1) @(negedge clk);
    end
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == exp, "R3 read data", {rsp_valid, rsp_rdata}, {1'b1, exp});
    chk(sel_n == 2'b11 && req_ready, "R7 idle gap", {sel_n, req_ready}, 3'b111);
    @(negedge clk);
    chk(!rsp_valid, "R3 pulse width", rsp_valid, 0);
    last_read = 1'b1;
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    int t = last_read ? TURN_CYC : 0;
    launch(1'b1, a, d);
    for (int i = 0; i < t; i++) begin
      chk(sel_n == 2'b11 && we_n && !oe && !req_ready, "R6 turnaround", {sel_n, we_n, oe}, 4'b1110);
      @(negedge clk);
    end
    for (int i = 0; i < WHZ_CYC; i++) begin
      chk(sel_n == sel_exp(a) && !we_n && !oe, "R4 hold-off", {sel_n, we_n, oe}, {sel_exp(a), 2'b00});
      chk(!req_ready, "R5 busy", req_ready, 0);
      @(negedge clk);
    end
    for (int i = 0; i < DRV_CYC; i++) begin
      chk(!we_n && oe, "R4 drive window", {we_n, oe}, 2'b01);
      chk(dq_o == d, "R10 write byte", dq_o, d);
      chk(sram_addr == a[18:0], "R1 address", sram_addr, a[18:0]);
      @(negedge clk);
    end
    chk(we_n && !oe && sel_n == 2'b11 && req_ready, "R4 release", {we_n, oe, sel_n, req_ready}, 5'b10111);
    shadow[a[19]][a[7:0]] = d;
    last_read = 1'b0;
  endtask

  task automatic test_reset();
    chk(sel_n == 2'b11 && we_n && !oe, "R9 pins", {sel_n, we_n, oe}, 4'b1110);
    chk(req_ready && !rsp_valid, "R9 port", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 256; a++) shadow[b][a] = init_val(b, a);
    repeat (3) @(negedge clk);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    test_reset();
    do_write(20'h00012, 8'ha5);          // lower bank, no turnaround
    do_write(20'h80012, 8'h3c);          // upper bank, same offset
    do_read(20'h00012);                  // R1 lower
    do_read(20'h80012);                  // R7 bank switch
    do_read(20'h80034);                  // untouched location
    do_write(20'h80034, 8'h77);          // R6 read then write
    do_read(20'h80034);
    do_write(20'h7ffff, 8'hc3);          // top of lower bank, R6 again
    do_read(20'hfffff);
    do_read(20'h7ffff);
    repeat (2) @(negedge clk);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    wd_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

endmodule